// File: doc/BRIEF.md
# AC-Link Codec Command and Status Register Front End

This block is the host-visible register front end of an AC-link audio controller. A host reaches five 32-bit registers over a simple single-cycle bus. Through them it sets the receive and transmit valid-slot masks, drives the codec reset and sync lines by hand, gates the link clock, and checks FIFO and error status. It also issues codec register reads and writes through one command/response word.

A command is held and flagged as pending until the slot serializer has carried it through a configurable number of link frames. Frame boundaries reach the block as a one-cycle `frame_tick`. When a read command completes, the codec's 16-bit answer is captured into the low half of the command/response word. The slot serializer, the sample FIFOs and DMA are outside this block. They appear only as the frame tick, the response data bus, FIFO flag inputs and error event pulses.

Top module: `ac97_regfront`

## Requirements
- R1: The configuration register at byte offset 0x00 holds bits 22:0 and reads back what was written, with bits 31:23 reading 0. Bits 22:13 drive `rx_slot_mask` and bits 12:3 drive `tx_slot_mask`. All bits reset to 0.
- R2: The enable register at offset 0x10 holds a clock-enable bit (bit 0) and a disable bit (bit 1), and reads them back in bits 1:0. It resets to 2'b10. `link_clk_en` is high only when clock-enable is 1 and disable is 0.
- R3: Configuration bit 0 set to 1 drives the active-low `codec_rst_n` low, and bit 0 at 0 releases it.
- R4: When configuration bit 2 (sync gate) is 1, `sync_out` follows configuration bit 1 (sync control). When bit 2 is 0, `sync_out` follows `link_sync_in`.
- R5: A write to offset 0x0C while no command is pending is accepted and raises `cmd_pending` on the next cycle. The write presents the index from bits 6:0 on `cmd_index`, the read flag from bit 7 on `cmd_is_read` (1 = read), and bits 31:16 on `cmd_wdata`.
- R6: A pending command clears after `CMD_FRAMES` frame ticks counted from the cycle after acceptance. It is still pending after one tick fewer.
- R7: When a read command completes, `codec_rsp_data` sampled on the completing tick appears in bits 15:0 of a read of offset 0x0C, with bits 31:16 reading 0. A completing write command leaves that value unchanged.
- R8: A write to offset 0x0C while a command is pending is ignored. The pending state, `cmd_index`, `cmd_is_read` and `cmd_wdata` all keep their values.
- R9: Reading offset 0x04 shows live flags: codec ready at bit 7, command pending at bit 6, tx empty at bit 4, tx full at bit 3, rx empty at bit 1 and rx full at bit 0. Bits 31:12, 5 and 2 read 0.
- R10: Status bits 11 (tx underflow), 10 (tx overflow), 9 (rx underflow) and 8 (rx overflow) are set by their event pulses and stay set. Writing 1 to a bit position at offset 0x04 clears that bit. An event in the same cycle as the clearing write wins.
- R11: The data register at offset 0x08 and unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 with `bus_en` |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_tick | input | 1 | One-cycle pulse per link frame |
| link_sync_in | input | 1 | Frame sync from the serializer |
| codec_rsp_data | input | 16 | Codec status data from the incoming frame |
| codec_ready | input | 1 | Codec ready indication |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rx_fifo_full | input | 1 | Receive FIFO full |
| tx_underrun_evt | input | 1 | Transmit underflow pulse |
| tx_overrun_evt | input | 1 | Transmit overflow pulse |
| rx_underrun_evt | input | 1 | Receive underflow pulse |
| rx_overrun_evt | input | 1 | Receive overflow pulse |
| codec_rst_n | output | 1 | Codec reset, active low |
| sync_out | output | 1 | Sync line to the codec |
| link_clk_en | output | 1 | Link clock gate enable |
| rx_slot_mask | output | 10 | Receive valid-slot mask |
| tx_slot_mask | output | 10 | Transmit valid-slot mask |
| cmd_pending | output | 1 | Command waiting for the link |
| cmd_index | output | 7 | Codec register index of held command |
| cmd_is_read | output | 1 | Held command is a read |
| cmd_wdata | output | 16 | Write data of held command |

## Verification
The hardest case to reach from the ports is a command write that arrives while another command is still pending, in the very cycle that the completing frame tick arrives. The accept path and the completion path then act on the same edge. The bench drives that collision directly: it starts a read, then issues a second command together with the final tick. It checks that the second command was dropped, that the first read's response was captured, and that the link reports idle afterwards. Randomized event pulses mixed with clear-on-write masks cover the set-beats-clear rule of the sticky bits.

// File: rtl/ac97rf_pkg.sv
// Shared offsets, field positions and types for the AC-link register front end.
package ac97rf_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_EN   = 5'h10;

    localparam int SLOT_W  = 10;
    localparam int TXM_LSB = 3;
    localparam int RXM_LSB = TXM_LSB + SLOT_W;
    localparam int CFG_W   = RXM_LSB + SLOT_W;

    localparam int IDX_W = 7;
    localparam int RSP_W = 16;

    // Held codec command
    typedef struct packed {
        logic [RSP_W-1:0] wdata;
        logic             rd;
        logic [IDX_W-1:0] idx;
    } cmd_t;
endpackage

// File: rtl/ac97rf_ctrl_regs.sv
// Configuration and enable registers with the pin controls derived from them.
// Assumes writes arrive as single-cycle strobes; reset and sync pins are
// combinational from register state so software sequences map one-to-one.
module ac97rf_ctrl_regs
    import ac97rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              en_we,
    input  logic [31:0]       wdata,
    input  logic              link_sync_in,
    output logic [31:0]       cfg_rd,
    output logic [31:0]       en_rd,
    output logic [SLOT_W-1:0] rx_mask,
    output logic [SLOT_W-1:0] tx_mask,
    output logic              codec_rst_n,
    output logic              sync_out,
    output logic              clk_en
);
    logic [CFG_W-1:0] cfg_q;
    logic [1:0]       en_q;

    // Register update for configuration and enable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            en_q  <= 2'b10;
        end else begin
            if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
            if (en_we)  en_q  <= wdata[1:0];
        end
    end

    // Pin and field decode
    always_comb begin
        cfg_rd      = {{(32-CFG_W){1'b0}}, cfg_q};
        en_rd       = {30'b0, en_q};
        rx_mask     = cfg_q[RXM_LSB +: SLOT_W];
        tx_mask     = cfg_q[TXM_LSB +: SLOT_W];
        codec_rst_n = ~cfg_q[0];
        sync_out    = cfg_q[2] ? cfg_q[1] : link_sync_in;
        clk_en      = en_q[0] & ~en_q[1];
    end
endmodule

// File: rtl/ac97rf_cmd_engine.sv
// Holds one codec command, keeps it pending for CMD_FRAMES frame ticks and
// captures the read response on the completing tick. Assumes frame_tick is a
// single-cycle pulse; writes while pending are dropped.
module ac97rf_cmd_engine
    import ac97rf_pkg::*;
#(
    parameter int CMD_FRAMES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      wdata,
    input  logic             frame_tick,
    input  logic [RSP_W-1:0] rsp_data,
    output logic             pending,
    output cmd_t             cmd,
    output logic [RSP_W-1:0] resp
);
    localparam int CW = $clog2(CMD_FRAMES + 1);

    logic [CW-1:0] left_q;

    // Accept, count down and complete the held command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            left_q  <= '0;
            cmd     <= '0;
            resp    <= '0;
        end else if (cmd_we && !pending) begin
            pending   <= 1'b1;
            left_q    <= CW'(CMD_FRAMES);
            cmd.idx   <= wdata[IDX_W-1:0];
            cmd.rd    <= wdata[7];
            cmd.wdata <= wdata[31:16];
        end else if (pending && frame_tick) begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
                pending <= 1'b0;
                if (cmd.rd) resp <= rsp_data;
            end
        end
    end
endmodule

// File: rtl/ac97rf_status.sv
// Status word: live FIFO/codec flags plus four sticky error bits cleared by
// writing ones. An event in the clearing cycle keeps its bit set.
module ac97rf_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stat_we,
    input  logic [31:0] wdata,
    input  logic [3:0]  err_evt,
    input  logic        codec_ready,
    input  logic        pending,
    input  logic        tx_empty,
    input  logic        tx_full,
    input  logic        rx_empty,
    input  logic        rx_full,
    output logic [3:0]  sticky_q,
    output logic [31:0] stat_rd
);
    logic [3:0] clr;

    // Clear mask from a status write
    always_comb clr = stat_we ? wdata[11:8] : 4'b0;

    // Sticky error bit update, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr) | err_evt;
    end

    // Status word assembly
    always_comb
        stat_rd = {20'b0, sticky_q, codec_ready, pending, 1'b0,
                   tx_empty, tx_full, 1'b0, rx_empty, rx_full};
endmodule

// File: rtl/ac97_regfront.sv
// Register front end of an AC-link controller: decodes the host bus into the
// control, command and status blocks and muxes the read word. Assumes a
// single-cycle bus with combinational read data and side-effect-free reads.
module ac97_regfront
    import ac97rf_pkg::*;
#(
    parameter int CMD_FRAMES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_tick,
    input  logic              link_sync_in,
    input  logic [RSP_W-1:0]  codec_rsp_data,
    input  logic              codec_ready,
    input  logic              tx_fifo_empty,
    input  logic              tx_fifo_full,
    input  logic              rx_fifo_empty,
    input  logic              rx_fifo_full,
    input  logic              tx_underrun_evt,
    input  logic              tx_overrun_evt,
    input  logic              rx_underrun_evt,
    input  logic              rx_overrun_evt,
    output logic              codec_rst_n,
    output logic              sync_out,
    output logic              link_clk_en,
    output logic [SLOT_W-1:0] rx_slot_mask,
    output logic [SLOT_W-1:0] tx_slot_mask,
    output logic              cmd_pending,
    output logic [IDX_W-1:0]  cmd_index,
    output logic              cmd_is_read,
    output logic [RSP_W-1:0]  cmd_wdata
);
    logic        wr;
    logic [31:0] cfg_rd, en_rd, stat_rd;
    logic [3:0]  err_evt, sticky_w;
    logic [RSP_W-1:0] resp;
    cmd_t        cmd;

    // Write strobe and event packing
    always_comb begin
        wr      = bus_en && bus_we;
        err_evt = {tx_underrun_evt, tx_overrun_evt, rx_underrun_evt, rx_overrun_evt};
    end

    ac97rf_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (wr && bus_addr == OFS_CFG),
        .en_we       (wr && bus_addr == OFS_EN),
        .wdata       (bus_wdata),
        .link_sync_in(link_sync_in),
        .cfg_rd      (cfg_rd),
        .en_rd       (en_rd),
        .rx_mask     (rx_slot_mask),
        .tx_mask     (tx_slot_mask),
        .codec_rst_n (codec_rst_n),
        .sync_out    (sync_out),
        .clk_en      (link_clk_en)
    );

    ac97rf_cmd_engine #(.CMD_FRAMES(CMD_FRAMES)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr && bus_addr == OFS_CMD),
        .wdata     (bus_wdata),
        .frame_tick(frame_tick),
        .rsp_data  (codec_rsp_data),
        .pending   (cmd_pending),
        .cmd       (cmd),
        .resp      (resp)
    );

    ac97rf_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (wr && bus_addr == OFS_STAT),
        .wdata      (bus_wdata),
        .err_evt    (err_evt),
        .codec_ready(codec_ready),
        .pending    (cmd_pending),
        .tx_empty   (tx_fifo_empty),
        .tx_full    (tx_fifo_full),
        .rx_empty   (rx_fifo_empty),
        .rx_full    (rx_fifo_full),
        .sticky_q   (sticky_w),
        .stat_rd    (stat_rd)
    );

    // Held command fields to the serializer
    always_comb begin
        cmd_index   = cmd.idx;
        cmd_is_read = cmd.rd;
        cmd_wdata   = cmd.wdata;
    end

    // Read mux; data port and unmapped offsets read zero
    always_comb begin
        unique case (bus_addr)
            OFS_CFG:  bus_rdata = cfg_rd;
            OFS_STAT: bus_rdata = stat_rd;
            OFS_CMD:  bus_rdata = {16'b0, resp};
            OFS_EN:   bus_rdata = en_rd;
            default:  bus_rdata = 32'b0;
        endcase
    end
endmodule

// File: rtl/ac97_regfront_chk.sv
// Protocol checks for ac97_regfront, attached by bind.
module ac97_regfront_chk
    import ac97rf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              frame_tick,
    input logic [3:0]        err_evt,
    input logic [3:0]        sticky_w,
    input logic              codec_rst_n,
    input logic              link_clk_en,
    input logic              cmd_pending,
    input logic [IDX_W-1:0]  cmd_index
);
    logic wcmd, wcfg, wen, wstat;
    always_comb begin
        wcmd  = bus_en && bus_we && bus_addr == OFS_CMD;
        wcfg  = bus_en && bus_we && bus_addr == OFS_CFG;
        wen   = bus_en && bus_we && bus_addr == OFS_EN;
        wstat = bus_en && bus_we && bus_addr == OFS_STAT;
    end

    assert_cmd_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wcmd && !cmd_pending |=> cmd_pending);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wcmd && cmd_pending && !frame_tick |=> cmd_pending && $stable(cmd_index));

    assert_codec_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wcfg && bus_wdata[0] |=> !codec_rst_n);

    assert_clock_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wen && bus_wdata[1:0] == 2'b01 |=> link_clk_en);

    assert_clock_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wen && bus_wdata[1] |=> !link_clk_en);

    assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt != 4'b0 |=> (sticky_w & $past(err_evt)) == $past(err_evt));

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wstat && err_evt == 4'b0 |=> $stable(sticky_w));
endmodule

bind ac97_regfront ac97_regfront_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .frame_tick (frame_tick),
    .err_evt    (err_evt),
    .sticky_w   (sticky_w),
    .codec_rst_n(codec_rst_n),
    .link_clk_en(link_clk_en),
    .cmd_pending(cmd_pending),
    .cmd_index  (cmd_index)
);

// File: tb/ac97_regfront_bench.sv
module ac97_regfront_bench;
    localparam int FR = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_en = 0, bus_we = 0;
    logic [4:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic frame_tick = 0, link_sync_in = 0;
    logic [15:0] codec_rsp_data = 0;
    logic codec_ready = 0, txe = 0, txf = 0, rxe = 0, rxf = 0;
    logic tu = 0, to = 0, ru = 0, ro = 0;
    logic codec_rst_n, sync_out, link_clk_en, cmd_pending, cmd_is_read;
    logic [9:0] rx_slot_mask, tx_slot_mask;
    logic [6:0] cmd_index;
    logic [15:0] cmd_wdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [3:0] m_sticky = 0;
    logic [15:0] m_resp = 0;

    always #5 clk = ~clk;

    ac97_regfront #(.CMD_FRAMES(FR)) u_ac97_regfront (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frame_tick(frame_tick), .link_sync_in(link_sync_in),
        .codec_rsp_data(codec_rsp_data), .codec_ready(codec_ready),
        .tx_fifo_empty(txe), .tx_fifo_full(txf), .rx_fifo_empty(rxe),
        .rx_fifo_full(rxf), .tx_underrun_evt(tu), .tx_overrun_evt(to),
        .rx_underrun_evt(ru), .rx_overrun_evt(ro), .codec_rst_n(codec_rst_n),
        .sync_out(sync_out), .link_clk_en(link_clk_en),
        .rx_slot_mask(rx_slot_mask), .tx_slot_mask(tx_slot_mask),
        .cmd_pending(cmd_pending), .cmd_index(cmd_index),
        .cmd_is_read(cmd_is_read), .cmd_wdata(cmd_wdata));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {20'b0, m_sticky, codec_ready, cmd_pending, 1'b0, txe, txf, 1'b0, rxe, rxf};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v;
        void'($urandom(32'h5eed_ac97));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        rd(5'h00, d); chk("R1 reset cfg", d, 0);
        rd(5'h10, d); chk("R2 reset enable", d, 32'h2);
        chk("R2 reset clk gate", link_clk_en, 0);
        chk("R3 reset codec_rst_n", codec_rst_n, 1);
        rd(5'h04, d); chk("R9 reset status", d, 0);
        chk("R5 reset pending", cmd_pending, 0);

        // Enable bring-up and shutdown
        wr(5'h10, 3); chk("R2 both bits", link_clk_en, 0);
        wr(5'h10, 1); chk("R2 clock on", link_clk_en, 1);
        rd(5'h10, d); chk("R2 readback", d, 1);
        wr(5'h10, 2); chk("R2 shutdown", link_clk_en, 0);

        // Random configuration, reset and sync pins
        for (int i = 0; i < 20; i++) begin
            v = $urandom;
            link_sync_in = $urandom;
            wr(5'h00, v);
            rd(5'h00, d); chk("R1 cfg readback", d, v & 32'h007F_FFFF);
            chk("R1 rx mask", rx_slot_mask, v[22:13]);
            chk("R1 tx mask", tx_slot_mask, v[12:3]);
            chk("R3 codec reset pin", codec_rst_n, !v[0]);
            chk("R4 sync pin", sync_out, v[2] ? v[1] : link_sync_in);
        end
        // Warm reset sequence
        wr(5'h00, 32'h6); chk("R4 warm high", sync_out, 1);
        wr(5'h00, 32'h4); chk("R4 warm low", sync_out, 0);
        link_sync_in = 1; wr(5'h00, 32'h0); chk("R4 released", sync_out, 1);
        // Cold reset sequence
        wr(5'h00, 32'h1); chk("R3 cold assert", codec_rst_n, 0);
        wr(5'h00, 32'h0); chk("R3 cold release", codec_rst_n, 1);

        // Read commands completing with random responses
        for (int i = 0; i < 8; i++) begin
            v = {$urandom_range(0, 16'hFFFF), 8'h0, 1'b1, 7'($urandom)};
            wr(5'h0C, v);
            chk("R5 pending", cmd_pending, 1);
            chk("R5 index", cmd_index, v[6:0]);
            chk("R5 read flag", cmd_is_read, 1);
            rd(5'h04, d); chk("R9 pending bit", d[6], 1);
            codec_rsp_data = $urandom;
            for (int k = 0; k < FR - 1; k++) tick();
            chk("R6 still pending", cmd_pending, 1);
            tick(); m_resp = codec_rsp_data;
            chk("R6 cleared", cmd_pending, 0);
            rd(5'h0C, d); chk("R7 response", d, {16'h0, m_resp});
        end

        // Write command: fields, and response untouched on completion
        v = 32'hBEEF_0035;
        wr(5'h0C, v);
        chk("R5 write flag", cmd_is_read, 0);
        chk("R5 write data", cmd_wdata, 16'hBEEF);
        codec_rsp_data = ~m_resp;
        for (int k = 0; k < FR; k++) tick();
        rd(5'h0C, d); chk("R7 write keeps response", d, {16'h0, m_resp});

        // Write while pending ignored
        wr(5'h0C, 32'h0000_0091);
        wr(5'h0C, 32'h1234_0022);
        chk("R8 index kept", cmd_index, 7'h11);
        chk("R8 read flag kept", cmd_is_read, 1);
        chk("R8 still pending", cmd_pending, 1);
        // Collision: ignored write with the completing tick
        for (int k = 0; k < FR - 1; k++) tick();
        codec_rsp_data = 16'hA5C3;
        @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = 5'h0C;
        bus_wdata = 32'h0000_0044; frame_tick = 1;
        @(negedge clk); bus_en = 0; bus_we = 0; frame_tick = 0;
        chk("R8 collide not accepted", cmd_pending, 0);
        chk("R8 collide index", cmd_index, 7'h11);
        rd(5'h0C, d); chk("R7 collide response", d, 32'h0000_A5C3);

        // Status: live flags, sticky events and clearing writes
        for (int i = 0; i < 40; i++) begin
            logic [3:0] ev, cl;
            logic wcl;
            ev = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            wcl = $urandom_range(0, 2) == 0;
            cl = $urandom;
            @(negedge clk);
            {codec_ready, txe, txf, rxe, rxf} = 5'($urandom);
            {tu, to, ru, ro} = ev;
            if (wcl) begin
                bus_en = 1; bus_we = 1; bus_addr = 5'h04; bus_wdata = {20'h0, cl, 8'hFF};
            end
            @(negedge clk);
            bus_en = 0; bus_we = 0; {tu, to, ru, ro} = 4'h0;
            m_sticky = (m_sticky & ~(wcl ? cl : 4'h0)) | ev;
            rd(5'h04, d); chk("R10 R9 status word", d, exp_status());
        end
        // Directed: set and clear in the same cycle
        @(negedge clk); tu = 1; bus_en = 1; bus_we = 1; bus_addr = 5'h04; bus_wdata = 32'hF00;
        @(negedge clk); tu = 0; bus_en = 0; bus_we = 0;
        rd(5'h04, d); chk("R10 set wins", d[11:8], 4'b1000);
        wr(5'h04, 32'hF00);
        rd(5'h04, d); chk("R10 cleared", d[11:8], 4'b0000);

        // Data register and unmapped offsets
        wr(5'h00, 32'h0000_1238);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, d); chk("R11 data reads zero", d, 0);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, d); chk("R11 unmapped zero", d, 0);
        rd(5'h00, d); chk("R11 cfg untouched", d, 32'h0000_1238);
        rd(5'h10, d); chk("R11 enable untouched", d, 32'h2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule